// File: doc/BRIEF.md
# Programmable XOR Channel Expander for Scan Compression

This block sits between a small number of tester channels and a much larger set of internal scan chains. On every shift cycle it takes N channel bits and produces M chain-head bits. Each head is the exclusive-OR of a chosen subset of the channels. For example, one head can be the parity of channels 0, 1 and 3 while its neighbour follows channel 2 alone. The mapping is purely combinational over the channel word and a stored tap matrix. It keeps no free-running or pseudo-random state, so a given channel word and matrix always give the same heads.

The tap matrix has M rows of N bits each. Row i selects the channels that feed head i, and bit j of a row set to 1 means channel j is included. Rows are written one per cycle through an address/data port. This lets one netlist serve whatever network a pattern tool has solved for. The head word and a shift-enable strobe are registered. Both appear on the cycle after a valid channel word is presented. Heads hold their value between valid words. Reconfiguration is locked out while channel data is flowing.

Top module: `xdec_top`

## Requirements
- R1: While rst_n is low, head_out and shift_en are 0 and every tap row is cleared to all zeros. As a result, the first valid word after reset yields all-zero heads.
- R2: When ch_valid is 1 at a rising edge, then after that edge head_out[i] equals the XOR of ch_data[j] over every j where bit j of tap row i is 1.
- R3: A head whose tap row is all zeros outputs 0 for every valid channel word.
- R4: shift_en is 1 in exactly the cycles that follow an edge at which ch_valid was 1, and 0 otherwise.
- R5: When ch_valid is 0 at an edge, head_out keeps its previous value.
- R6: A write (cfg_we = 1) that occurs at an edge where ch_valid is 1 is discarded and leaves every tap row unchanged.
- R7: A write with ch_valid = 0 replaces row cfg_addr with cfg_row. The new row is used by the next valid word, and all other rows keep their contents. A valid word in the same cycle as an accepted write is not possible, because of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Channel word is valid this cycle |
| ch_data | input | N_CH | Tester channel bits |
| cfg_we | input | 1 | Tap row write strobe |
| cfg_addr | input | clog2(M_HEADS) | Row (head index) to write |
| cfg_row | input | N_CH | Channel-select bits for that row |
| head_out | output | M_HEADS | Registered chain-head bits |
| shift_en | output | 1 | High in the cycle the heads carry a new word |

## Verification
A corrupted tap row shows up at the affected head on the very next valid word whose channels overlap the bad bits. Random channel words therefore expose it within a few cycles. A write that leaks through while data is valid stays invisible until a later valid word. For that reason, every ignored-write case is followed immediately by a valid word that exercises the targeted row. A stuck or mistimed shift-enable, or a head register that drifts when no word is valid, is visible one cycle after the offending edge.

// File: rtl/xdec_pkg.sv
package xdec_pkg;
    localparam int unsigned XDEC_N_DEF = 4;
    localparam int unsigned XDEC_M_DEF = 16;

    function automatic int unsigned xdec_aw(input int unsigned m);
        return (m < 2) ? 1 : $clog2(m);
    endfunction
endpackage

// File: rtl/xdec_tap_store.sv
module xdec_tap_store #(
    parameter int unsigned N_CH    = xdec_pkg::XDEC_N_DEF,
    parameter int unsigned M_HEADS = xdec_pkg::XDEC_M_DEF,
    localparam int unsigned AW     = xdec_pkg::xdec_aw(M_HEADS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      lock,
    input  logic [AW-1:0]             wr_addr,
    input  logic [N_CH-1:0]           wr_row,
    output logic [M_HEADS*N_CH-1:0]   taps_flat
);
    logic [M_HEADS-1:0][N_CH-1:0] rows_d, rows_q;

    always_comb begin
        rows_d = rows_q;
        if (wr_en && !lock && (32'(wr_addr) < M_HEADS)) begin
            rows_d[wr_addr] = wr_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rows_q <= '0;
        else        rows_q <= rows_d;
    end

    assign taps_flat = rows_q;
endmodule

// File: rtl/xdec_xor_net.sv
module xdec_xor_net #(
    parameter int unsigned N_CH    = xdec_pkg::XDEC_N_DEF,
    parameter int unsigned M_HEADS = xdec_pkg::XDEC_M_DEF
) (
    input  logic [N_CH-1:0]         ch,
    input  logic [M_HEADS*N_CH-1:0] taps_flat,
    output logic [M_HEADS-1:0]      heads
);
    for (genvar h = 0; h < M_HEADS; h++) begin : g_head
        logic [N_CH-1:0] sel;
        assign sel      = taps_flat[h*N_CH +: N_CH] & ch;
        assign heads[h] = ^sel;
    end
endmodule

// File: rtl/xdec_top.sv
module xdec_top #(
    parameter int unsigned N_CH    = xdec_pkg::XDEC_N_DEF,
    parameter int unsigned M_HEADS = xdec_pkg::XDEC_M_DEF,
    localparam int unsigned AW     = xdec_pkg::xdec_aw(M_HEADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ch_valid,
    input  logic [N_CH-1:0]    ch_data,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [N_CH-1:0]    cfg_row,
    output logic [M_HEADS-1:0] head_out,
    output logic               shift_en
);
    typedef struct packed {
        logic [M_HEADS-1:0] heads;
        logic               shift;
    } out_state_t;

    logic [M_HEADS*N_CH-1:0] taps_flat;
    logic [M_HEADS-1:0]      heads_comb;
    out_state_t              st_d, st_q;

    xdec_tap_store #(.N_CH(N_CH), .M_HEADS(M_HEADS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .lock      (ch_valid),
        .wr_addr   (cfg_addr),
        .wr_row    (cfg_row),
        .taps_flat (taps_flat)
    );

    xdec_xor_net #(.N_CH(N_CH), .M_HEADS(M_HEADS)) u_net (
        .ch        (ch_data),
        .taps_flat (taps_flat),
        .heads     (heads_comb)
    );

    always_comb begin
        st_d       = st_q;
        st_d.shift = ch_valid;
        if (ch_valid) st_d.heads = heads_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_out = st_q.heads;
    assign shift_en = st_q.shift;
endmodule

// File: rtl/xdec_checker.sv
module xdec_checker #(
    parameter int unsigned N_CH    = xdec_pkg::XDEC_N_DEF,
    parameter int unsigned M_HEADS = xdec_pkg::XDEC_M_DEF
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ch_valid,
    input logic                    cfg_we,
    input logic [M_HEADS-1:0]      head_out,
    input logic                    shift_en,
    input logic [M_HEADS*N_CH-1:0] taps_flat
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (head_out == '0 && !shift_en && taps_flat == '0)); // R1

    AST_SHIFT_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |=> shift_en); // R4

    AST_SHIFT_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> !shift_en); // R4

    AST_HEADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> $stable(head_out)); // R5

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && cfg_we) |=> $stable(taps_flat)); // R6

    for (genvar h = 0; h < M_HEADS; h++) begin : g_zero
        AST_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_valid && taps_flat[h*N_CH +: N_CH] == '0) |=> !head_out[h]); // R3
    end
endmodule

bind xdec_top xdec_checker #(.N_CH(N_CH), .M_HEADS(M_HEADS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_valid  (ch_valid),
    .cfg_we    (cfg_we),
    .head_out  (head_out),
    .shift_en  (shift_en),
    .taps_flat (taps_flat)
);

// File: tb/xdec_top_bench.sv
module xdec_top_bench;
    localparam int N  = 4;
    localparam int M  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch_valid = 1'b0;
    logic [N-1:0]  ch_data = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [N-1:0]  cfg_row = '0;
    logic [M-1:0]  head_out;
    logic          shift_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [N-1:0] mdl [M];
    logic [M-1:0] exp_heads;

    always #4 clk = ~clk;

    xdec_top #(.N_CH(N), .M_HEADS(M)) u_xdec_top (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_row(cfg_row),
        .head_out(head_out), .shift_en(shift_en)
    );

    function automatic logic [M-1:0] expand(input logic [N-1:0] ch);
        logic [M-1:0] r;
        for (int h = 0; h < M; h++) r[h] = ^(mdl[h] & ch);
        return r;
    endfunction

    task automatic check(input string tag, input logic [M-1:0] exp_h, input logic exp_s);
        n_checks++;
        if (head_out !== exp_h || shift_en !== exp_s) begin
            n_fail++;
            $display("FAIL %s: heads=%h shift=%b expected heads=%h shift=%b",
                     tag, head_out, shift_en, exp_h, exp_s);
        end
    endtask

    // drive at negedge, let one posedge pass, check at the following negedge
    task automatic cycle(input logic v, input logic [N-1:0] ch, input logic we,
                         input logic [AW-1:0] a, input logic [N-1:0] row, input string tag);
        ch_valid = v; ch_data = ch; cfg_we = we; cfg_addr = a; cfg_row = row;
        if (v) exp_heads = expand(ch);
        @(negedge clk);
        check(tag, exp_heads, v);
        if (we && !v) mdl[a] = row;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int h = 0; h < M; h++) mdl[h] = '0;
        exp_heads = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", '0, 1'b0);
        cycle(1'b1, 4'b1111, 1'b0, '0, '0, "R1 cleared taps");

        // R7: program rows, with idle cycles checked for R5/R4
        cycle(1'b0, '0, 1'b1, 4'd0, 4'b1011, "R5");
        cycle(1'b0, '0, 1'b1, 4'd1, 4'b0100, "R5");
        cycle(1'b0, '0, 1'b1, 4'd2, 4'b1111, "R5");
        cycle(1'b1, 4'b1001, 1'b0, '0, '0, "R7 new rows used");
        cycle(1'b1, 4'b0110, 1'b0, '0, '0, "R2 directed");
        cycle(1'b0, 4'b1111, 1'b0, '0, '0, "R5 hold, R4 low");

        // R3: zero row 3 stays low for all channel words
        for (int c = 0; c < 16; c++) begin
            cycle(1'b1, 4'(c), 1'b0, '0, '0, "R3 zero row");
            n_checks++;
            if (head_out[3] !== 1'b0) begin
                n_fail++;
                $display("FAIL R3: head3=%b expected 0", head_out[3]);
            end
        end

        // R6: write during valid ignored, then row 0 exercised
        cycle(1'b1, 4'b0001, 1'b1, 4'd0, 4'b0000, "R6 locked write");
        cycle(1'b1, 4'b0001, 1'b0, '0, '0, "R6 row0 unchanged");
        n_checks++;
        if (head_out[0] !== 1'b1) begin
            n_fail++;
            $display("FAIL R6: head0=%b expected 1", head_out[0]);
        end

        // R7: rewrite one row, others preserved
        cycle(1'b0, '0, 1'b1, 4'd15, 4'b0010, "R5");
        cycle(1'b1, 4'b0011, 1'b0, '0, '0, "R7 rewrite row 15");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic v, we;
            v  = ($urandom % 3) != 0;
            we = ($urandom % 2) == 0;
            cycle(v, N'($urandom), we, AW'($urandom), N'($urandom),
                  v ? "R2 R4 R6 random" : "R4 R5 R7 random");
        end

        // R1: reset mid-run clears taps again
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", '0, 1'b0);
        for (int h = 0; h < M; h++) mdl[h] = '0;
        exp_heads = '0;
        rst_n = 1'b1;
        cycle(1'b1, 4'b1010, 1'b0, '0, '0, "R1 taps cleared");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule